// File: doc/BRIEF.md
# Raster Timing Generator with Border and Display Window

This block produces the horizontal and vertical timing of a video raster from a small set of programmed registers. It runs a pixel counter along each line and a line counter down each field. From these counts it produces sync pulses, a field flag for interlaced output, a border region and a display window. The border and the window are placed independently of each other. Inside the window it strobes the pixel-fetch request and gives the index of the 32-bit word, counted from the start of the line, that the request refers to.

Software programs the block through a single-cycle write port. Every write lands in a shadow copy of the registers. The live copy, which drives all timing, is updated only when the raster enters vertical retrace, so a mode change never tears a frame. When the display is disabled, the live copy is updated on the next clock. A pending flag shows that a shadow write has not yet reached the live copy.

Three mode bits change the window without moving its origin. Horizontal pixel doubling makes each word take two clocks. Line doubling makes each window line repeat. Blanking removes the window and turns the whole visible span into border.

Top module: `raster_gen`

## Requirements
- R1: While rst_ni is low, and after reset until the first write, every output is low, word_idx_o is 0 and pending_o is 0.
- R2: With the display enabled, a line lasts H clocks and a field lasts V lines, where H and V are the programmed totals. hsync_o is high for the first HSYNC_CLKS clocks of each line. vsync_o is high for the first VSYNC_LINES lines of each field.
- R3: Register map, selected by wr_addr_i. 0: totals, with V in [25:16] and H in [9:0]. 1: horizontal border, with start in [25:16] and stop in [9:0]. 2: vertical border, with the same layout. 3: window horizontal start in [9:0]. 4: window vertical start, with field 1 in [25:16] and field 0 in [9:0]. 5: window size, with lines minus one in [19:10], words minus one in [9:0], and bits [29:20] ignored. 6: control, with bit 0 display enable and bit 1 line doubling. 7: config, with bit 0 pixel doubling, bit 3 blank and bit 4 interlace.
- R4: A write sets pending_o and changes only the shadow copy. The live copy is loaded on the clock that starts vertical sync (line 0, pixel 0), or on the next clock if the display is disabled. pending_o then clears. Until that load, the outputs follow the old settings.
- R5: border_o is high on pixels inside both the horizontal span [start, stop) and the vertical span [start, stop), except where window_o is high.
- R6: window_o is high from the horizontal window start for (words+1) clocks, on lines from the vertical start for (lines+1) lines. fetch_o is high on every window clock. word_idx_o equals the clock offset from the window start, and is 0 outside the window.
- R7: With pixel doubling, the window is 2*(words+1) clocks wide. fetch_o is high only on even offsets, and word_idx_o equals the offset divided by 2.
- R8: With line doubling, the window spans 2*(lines+1) lines.
- R9: With blank set, window_o and fetch_o stay low and border_o covers the whole visible span.
- R10: With interlace set, field_o toggles each time the line counter wraps, and the window starts on the field-1 vertical start while field_o is 1. Without interlace, field_o is 0.
- R11: With the display disabled, the counters hold at zero and every timing output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | Current interlace field |
| border_o | output | 1 | Pixel lies in the border region |
| window_o | output | 1 | Pixel lies in the display window |
| fetch_o | output | 1 | Pixel-fetch strobe |
| word_idx_o | output | 10 | Line-relative word index of the fetch |
| pending_o | output | 1 | A shadow write awaits transfer to the live copy |

## Verification
The hardest condition to reach from the ports is a register write that arrives mid-frame, followed by a look at the raster before the next retrace. That is the only window in which a missing deferral shows. The bench locks onto the trailing edge of vsync_o to learn the raster position. It writes pixel doubling at that point and walks a counted number of clocks to a pixel where the old and new settings give different word indices. Interlace needs consecutive frames, so the field scans run back to back, with each scan ending just before the next field's sync.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned CW = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    RA_TOTALS = 3'd0,
    RA_BORD_H = 3'd1,
    RA_BORD_V = 3'd2,
    RA_WIN_H  = 3'd3,
    RA_WIN_V  = 3'd4,
    RA_WIN_SZ = 3'd5,
    RA_CTRL   = 3'd6,
    RA_CFG    = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [CW-1:0] h_total;
    logic [CW-1:0] v_total;
    logic [CW-1:0] bh_start;
    logic [CW-1:0] bh_stop;
    logic [CW-1:0] bv_start;
    logic [CW-1:0] bv_stop;
    logic [CW-1:0] wh_start;
    logic [CW-1:0] wv_start0;
    logic [CW-1:0] wv_start1;
    logic [CW-1:0] w_words_m1;
    logic [CW-1:0] w_lines_m1;
    logic          disp_en;
    logic          line_dbl;
    logic          pix_dbl;
    logic          blank;
    logic          interlace;
  } raster_cfg_t;

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 frame_end_i,
  output raster_cfg_t          cfg_o,
  output logic                 pending_o
);

  localparam int unsigned HI = 16;

  raster_cfg_t shadow_q, live_q;
  logic        pending_q;
  logic        load;
  logic        unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[DW-1:HI+CW];

  // live copy follows shadow at retrace, or at once while the display is off
  assign load = pending_q && (frame_end_i || !live_q.disp_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        RA_TOTALS: begin
          shadow_q.v_total <= wr_data_i[HI +: CW];
          shadow_q.h_total <= wr_data_i[0 +: CW];
        end
        RA_BORD_H: begin
          shadow_q.bh_start <= wr_data_i[HI +: CW];
          shadow_q.bh_stop  <= wr_data_i[0 +: CW];
        end
        RA_BORD_V: begin
          shadow_q.bv_start <= wr_data_i[HI +: CW];
          shadow_q.bv_stop  <= wr_data_i[0 +: CW];
        end
        RA_WIN_H:  shadow_q.wh_start <= wr_data_i[0 +: CW];
        RA_WIN_V: begin
          shadow_q.wv_start1 <= wr_data_i[HI +: CW];
          shadow_q.wv_start0 <= wr_data_i[0 +: CW];
        end
        RA_WIN_SZ: begin
          shadow_q.w_lines_m1 <= wr_data_i[CW +: CW];
          shadow_q.w_words_m1 <= wr_data_i[0 +: CW];
        end
        RA_CTRL: begin
          shadow_q.disp_en  <= wr_data_i[0];
          shadow_q.line_dbl <= wr_data_i[1];
        end
        default: begin
          shadow_q.pix_dbl   <= wr_data_i[0];
          shadow_q.blank     <= wr_data_i[3];
          shadow_q.interlace <= wr_data_i[4];
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      if (load) live_q <= shadow_q;
      if (wr_en_i)   pending_q <= 1'b1;
      else if (load) pending_q <= 1'b0;
    end
  end

  assign cfg_o     = live_q;
  assign pending_o = pending_q;

  a_r4_pend_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> pending_q);

  a_r4_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q.disp_en && !frame_end_i) |=> $stable(live_q));

  a_r4_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && frame_end_i && !wr_en_i) |=> !pending_q);

endmodule

// File: rtl/raster_counters.sv
module raster_counters
  import raster_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          interlace_i,
  input  logic [CW-1:0] h_total_i,
  input  logic [CW-1:0] v_total_i,
  output logic [CW-1:0] h_cnt_o,
  output logic [CW-1:0] v_cnt_o,
  output logic          field_o,
  output logic          frame_end_o
);

  localparam int unsigned XW = CW + 1;

  logic [CW-1:0] h_cnt_q, v_cnt_q;
  logic          field_q;
  logic          h_last, v_last;

  // a total of 0 or 1 degenerates to a one-count period
  assign h_last = (XW'(h_cnt_q) + XW'(1)) >= XW'(h_total_i);
  assign v_last = (XW'(v_cnt_q) + XW'(1)) >= XW'(v_total_i);
  assign frame_end_o = en_i && h_last && v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_q <= '0;
      v_cnt_q <= '0;
      field_q <= 1'b0;
    end else if (!en_i) begin
      h_cnt_q <= '0;
      v_cnt_q <= '0;
      field_q <= 1'b0;
    end else if (h_last) begin
      h_cnt_q <= '0;
      if (v_last) begin
        v_cnt_q <= '0;
        field_q <= interlace_i ? !field_q : 1'b0;
      end else begin
        v_cnt_q <= v_cnt_q + CW'(1);
      end
    end else begin
      h_cnt_q <= h_cnt_q + CW'(1);
    end
  end

  assign h_cnt_o = h_cnt_q;
  assign v_cnt_o = v_cnt_q;
  assign field_o = field_q;

  a_r2_h_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (XW'(h_cnt_q) + XW'(1) < XW'(h_total_i))) |=> h_cnt_q == $past(h_cnt_q) + CW'(1));

  a_r2_h_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && h_total_i != '0 && h_cnt_q == h_total_i - CW'(1)) |=> h_cnt_q == '0);

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (h_cnt_q == '0 && v_cnt_q == '0 && !field_q));

  a_r10_field_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frame_end_o) |=> $stable(field_q));

endmodule

// File: rtl/raster_window.sv
module raster_window
  import raster_pkg::*;
#(
  parameter int unsigned HSYNC_CLKS  = 8,
  parameter int unsigned VSYNC_LINES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  raster_cfg_t   cfg_i,
  input  logic [CW-1:0] h_cnt_i,
  input  logic [CW-1:0] v_cnt_i,
  input  logic          field_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          border_o,
  output logic          window_o,
  output logic          fetch_o,
  output logic [CW-1:0] word_idx_o
);

  localparam int unsigned XW = CW + 2;
  localparam logic [CW-1:0] HS_LIM = CW'(HSYNC_CLKS);
  localparam logic [CW-1:0] VS_LIM = CW'(VSYNC_LINES);

  logic [XW-1:0] h_x, v_x, wh_lo, wh_hi, wv_lo, wv_hi;
  logic [CW-1:0] rel;
  logic          in_vis, in_win;

  assign h_x   = XW'(h_cnt_i);
  assign v_x   = XW'(v_cnt_i);
  assign wh_lo = XW'(cfg_i.wh_start);
  assign wh_hi = wh_lo + ((XW'(cfg_i.w_words_m1) + XW'(1)) << cfg_i.pix_dbl);
  assign wv_lo = XW'(field_i ? cfg_i.wv_start1 : cfg_i.wv_start0);
  assign wv_hi = wv_lo + ((XW'(cfg_i.w_lines_m1) + XW'(1)) << cfg_i.line_dbl);

  assign in_vis = cfg_i.disp_en &&
                  h_cnt_i >= cfg_i.bh_start && h_cnt_i < cfg_i.bh_stop &&
                  v_cnt_i >= cfg_i.bv_start && v_cnt_i < cfg_i.bv_stop;

  assign in_win = cfg_i.disp_en && !cfg_i.blank &&
                  h_x >= wh_lo && h_x < wh_hi && v_x >= wv_lo && v_x < wv_hi;

  assign rel = h_cnt_i - cfg_i.wh_start;

  assign hsync_o    = cfg_i.disp_en && (h_cnt_i < HS_LIM);
  assign vsync_o    = cfg_i.disp_en && (v_cnt_i < VS_LIM);
  assign window_o   = in_win;
  assign border_o   = in_vis && !in_win;
  assign fetch_o    = in_win && (!cfg_i.pix_dbl || !rel[0]);
  assign word_idx_o = !in_win ? '0 : (cfg_i.pix_dbl ? (rel >> 1) : rel);

  a_r6_fetch_in_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> window_o);

  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(border_o && window_o));

  a_r9_blank_no_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.blank |-> (!window_o && !fetch_o));

  a_r11_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.disp_en |-> !(hsync_o || vsync_o || border_o || window_o));

endmodule

// File: rtl/raster_gen.sv
module raster_gen
  import raster_pkg::*;
#(
  parameter int unsigned HSYNC_CLKS  = 8,
  parameter int unsigned VSYNC_LINES = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [2:0]                wr_addr_i,
  input  logic [31:0]               wr_data_i,
  output logic                      hsync_o,
  output logic                      vsync_o,
  output logic                      field_o,
  output logic                      border_o,
  output logic                      window_o,
  output logic                      fetch_o,
  output logic [raster_pkg::CW-1:0] word_idx_o,
  output logic                      pending_o
);

  raster_cfg_t   cfg;
  logic [CW-1:0] h_cnt, v_cnt;
  logic          field, frame_end;

  raster_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .frame_end_i (frame_end),
    .cfg_o       (cfg),
    .pending_o   (pending_o)
  );

  raster_counters u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg.disp_en),
    .interlace_i (cfg.interlace),
    .h_total_i   (cfg.h_total),
    .v_total_i   (cfg.v_total),
    .h_cnt_o     (h_cnt),
    .v_cnt_o     (v_cnt),
    .field_o     (field),
    .frame_end_o (frame_end)
  );

  raster_window #(
    .HSYNC_CLKS  (HSYNC_CLKS),
    .VSYNC_LINES (VSYNC_LINES)
  ) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .h_cnt_i    (h_cnt),
    .v_cnt_i    (v_cnt),
    .field_i    (field),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .border_o   (border_o),
    .window_o   (window_o),
    .fetch_o    (fetch_o),
    .word_idx_o (word_idx_o)
  );

  assign field_o = field;

endmodule

// File: tb/raster_gen_bench.sv
`timescale 1ns/1ps
module raster_gen_bench;

  localparam int HS = 8;
  localparam int VS = 3;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        hsync_o, vsync_o, field_o, border_o, window_o, fetch_o, pending_o;
  logic [9:0]  word_idx_o;

  always #4 clk = ~clk;

  raster_gen #(.HSYNC_CLKS(HS), .VSYNC_LINES(VS)) u_raster_gen (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .field_o(field_o), .border_o(border_o), .window_o(window_o),
    .fetch_o(fetch_o), .word_idx_o(word_idx_o), .pending_o(pending_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int c_ht = 24, c_vt = 14, c_bsh = 10, c_bph = 22, c_bsv = 4, c_bpv = 13;
  int c_wsh = 12, c_wv0 = 5, c_wv1 = 7, c_wm1 = 3, c_lm1 = 1;
  bit c_pd = 0, c_ld = 0, c_bl = 0;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_loaded();
    for (int i = 0; i < 2000; i++) begin
      if (!pending_o) break;
      @(negedge clk);
    end
  endtask

  task automatic apply(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    wait_loaded();
  endtask

  // ends on the negedge where vsync_o has just dropped: pixel 0 of line VS
  task automatic sync_frame();
    bit prev;
    prev = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (prev && !vsync_o) return;
      prev = vsync_o;
    end
  endtask

  function automatic logic [14:0] model(input int h, input int v, input bit fld);
    int wv, wl, hl, off;
    bit vis, win, brd, fet;
    int word;
    wv  = fld ? c_wv1 : c_wv0;
    wl  = (c_wm1 + 1) * (c_pd ? 2 : 1);
    hl  = (c_lm1 + 1) * (c_ld ? 2 : 1);
    off = h - c_wsh;
    vis = h >= c_bsh && h < c_bph && v >= c_bsv && v < c_bpv;
    win = !c_bl && h >= c_wsh && h < c_wsh + wl && v >= wv && v < wv + hl;
    brd = vis && !win;
    fet = win && (!c_pd || (off % 2 == 0));
    word = win ? (c_pd ? off / 2 : off) : 0;
    return {h < HS, v < VS, brd, win, fet, word[9:0]};
  endfunction

  task automatic scan(input string req, input bit fld);
    sync_frame();
    chk(req, field_o, fld, "field at frame start");
    for (int v = VS; v < c_vt; v++) begin
      for (int h = 0; h < c_ht; h++) begin
        chk(req, {hsync_o, vsync_o, border_o, window_o, fetch_o, word_idx_o},
            model(h, v, fld), $sformatf("raster at h=%0d v=%0d", h, v));
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", {hsync_o, vsync_o, field_o, border_o, window_o, fetch_o, pending_o}, 0, "outputs in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {hsync_o, vsync_o, field_o, border_o, window_o, fetch_o, pending_o, word_idx_o}, 0, "outputs after reset");
  endtask

  // R3 encodings; display off, so each write loads on the next clock
  task automatic t_base();
    apply(3'd0, (c_vt << 16) | c_ht);
    apply(3'd1, (c_bsh << 16) | c_bph);
    apply(3'd2, (c_bsv << 16) | c_bpv);
    apply(3'd3, c_wsh);
    apply(3'd4, (c_wv1 << 16) | c_wv0);
    apply(3'd5, (32'h3ff << 20) | (c_lm1 << 10) | c_wm1);
    apply(3'd6, 32'h1);
    chk("R4", pending_o, 0, "pending after load while disabled");
    scan("R5", 1'b0);
    scan("R6", 1'b0);
  endtask

  task automatic t_defer();
    sync_frame();
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4", pending_o, 1, "pending after mid-frame write");
    repeat (2 * c_ht + 12) @(negedge clk);
    chk("R4", word_idx_o, 1, "old word index before retrace");
    chk("R4", fetch_o, 1, "old fetch before retrace");
    chk("R4", pending_o, 1, "pending held until retrace");
    c_pd = 1'b1;
    scan("R7", 1'b0);
    chk("R4", pending_o, 0, "pending cleared after retrace");
  endtask

  task automatic t_line_dbl();
    apply(3'd6, 32'h3);
    c_ld = 1'b1;
    scan("R8", 1'b0);
  endtask

  task automatic t_blank();
    apply(3'd7, 32'h9);
    c_bl = 1'b1;
    scan("R9", 1'b0);
    apply(3'd7, 32'h1);
    c_bl = 1'b0;
  endtask

  task automatic t_sync_counts();
    int nv, nh;
    nv = 0; nh = 0;
    sync_frame();
    for (int i = 0; i < c_ht * c_vt; i++) begin
      nv += vsync_o ? 1 : 0;
      nh += hsync_o ? 1 : 0;
      @(negedge clk);
    end
    chk("R2", nv, VS * c_ht, "vsync clocks per frame");
    chk("R2", nh, HS * c_vt, "hsync clocks per frame");
    chk("R2", vsync_o, 0, "position repeats after one frame");
  endtask

  task automatic t_interlace();
    apply(3'd7, 32'h11);
    scan("R10", 1'b0);
    scan("R10", 1'b1);
    scan("R10", 1'b0);
  endtask

  task automatic t_disable();
    apply(3'd6, 32'h0);
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      chk("R11", {hsync_o, vsync_o, field_o, border_o, window_o, fetch_o, word_idx_o}, 0, "outputs while disabled");
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_base();
    t_defer();
    t_line_dbl();
    t_blank();
    t_sync_counts();
    t_interlace();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule